// File: doc/BRIEF.md
# Even/Odd Dual-Issue Dispatch Logic

This block sits between an instruction fetch buffer and two execution pipes, called the even pipe and the odd pipe. Each cycle the fetch buffer presents a pair of 32-bit instruction words in program order. Each word comes with its word address and a pre-decoded 3-bit class. The block decides whether both words can leave together, one per pipe, or whether they must leave one after the other. It holds the fetch buffer with a stall signal until the whole pair has left.

A pair goes out together only when all of the following hold:
- The first word sits at an even word address and the second at the next word address.
- The first word belongs to the even pipe and the second to the odd pipe.
- The second word neither reads nor overwrites the first word's destination.

In every other case the first word issues alone. The second word follows it in order.

A per-register latency scoreboard holds any word whose source registers still wait for a result. The scoreboard is loaded from a fixed latency for each class. Issued words appear on registered per-pipe outputs one cycle after the issue decision.

Top module: `dual_issue_dispatch`

## Requirements
- R1: After reset, both pipe valid outputs are low, `fetch_stall` is low while `pair_valid` is low, and no register is marked busy.
- R2: Word fields are fixed as follows:
  - Bits [6:0] hold the destination register.
  - Bits [13:7], [20:14] and [27:21] hold source registers A, B and C.
  - Bits 29, 30 and 31 mark sources A, B and C as used.
  - Class bit 2 selects the pipe: 0 is even, 1 is odd.
  - Class result latencies are 2, 4, 6, 7, 4, 6, 4 and 6 cycles for classes 0 to 7.
- R3: The pair issues in the same cycle on both pipes when all of these hold:
  - The first address is even and the second address equals the first plus one.
  - The first class is even-pipe and the second class is odd-pipe.
  - The pair is independent.
  - Neither word waits on the scoreboard.
- R4: When the address or class condition of R3 fails, the first word issues alone. The second word issues on the following cycle if its sources are ready.
- R5: If the second word uses the first word's destination as a source, the pair issues sequentially. The second word appears exactly L cycles after the first, where L is the first word's class latency.
- R6: If both words write the same destination, the pair issues sequentially and never on both pipes in one cycle.
- R7: A word that reads a busy register issues exactly L cycles after its producer issued, where L is the producer's class latency.
- R8: `fetch_stall` is high in every cycle where `pair_valid` is high and the pair is not fully issued. It is low in the cycle where the last word of the pair is issued.
- R9: A source register whose use bit is clear never delays issue and never breaks pairing.
- R10: A word always leaves on the pipe given by its class bit 2, whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | Fetch buffer presents a pair |
| ins0_word | input | 32 | First (older) instruction word |
| ins0_addr | input | ADDR_W | Word address of first word |
| ins0_cls | input | 3 | Class of first word |
| ins1_word | input | 32 | Second (younger) instruction word |
| ins1_addr | input | ADDR_W | Word address of second word |
| ins1_cls | input | 3 | Class of second word |
| fetch_stall | output | 1 | Pair not yet fully issued; hold it |
| even_valid | output | 1 | Even pipe receives a word |
| even_word | output | 32 | Word sent to the even pipe |
| even_cls | output | 3 | Class of the even-pipe word |
| odd_valid | output | 1 | Odd pipe receives a word |
| odd_word | output | 32 | Word sent to the odd pipe |
| odd_cls | output | 3 | Class of the odd-pipe word |

## Verification
The embedded properties are checked on every cycle:
- Each pipe only ever receives words of its own class.
- A same-cycle pair never shares a destination.
- A same-cycle pair came from an even first address.
- Every issued destination is marked busy.
- Scoreboard counters step down by one when not reloaded.

The exact issue distances between producers and consumers for every class, the fallback to sequential order and its ordering, the handling of unused sources, and the number of stall cycles seen by fetch can only be shown by the bench's directed scenarios.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
    localparam int WORD_W = 32;
    localparam int CLS_W  = 3;
    localparam int REG_N  = 128;
    localparam int REG_W  = $clog2(REG_N);
    localparam int NSRC   = 3;
    localparam int MAX_LAT = 7;
    localparam int CNT_W  = $clog2(MAX_LAT);

    typedef struct packed {
        logic              v;
        logic [WORD_W-1:0] word;
        logic [CLS_W-1:0]  cls;
    } slot_t;

    // Result latency per class, minus one (scoreboard load value)
    function automatic logic [CNT_W-1:0] wait_of(input logic [CLS_W-1:0] c);
        logic [CNT_W-1:0] r;
        case (c)
            3'd0:    r = CNT_W'(1);
            3'd1:    r = CNT_W'(3);
            3'd2:    r = CNT_W'(5);
            3'd3:    r = CNT_W'(6);
            3'd4:    r = CNT_W'(3);
            3'd5:    r = CNT_W'(5);
            3'd6:    r = CNT_W'(3);
            default: r = CNT_W'(5);
        endcase
        return r;
    endfunction

    function automatic logic [REG_W-1:0] f_dst(input logic [WORD_W-1:0] w);
        return w[REG_W-1:0];
    endfunction

    function automatic logic [REG_W-1:0] f_src(input logic [WORD_W-1:0] w, input int i);
        return w[REG_W*(i+1) +: REG_W];
    endfunction

    function automatic logic f_use(input logic [WORD_W-1:0] w, input int i);
        return w[WORD_W-NSRC+i];
    endfunction
endpackage

// File: rtl/dd_scoreboard.sv
module dd_scoreboard
    import dispatch_pkg::*;
#(
    parameter int N = REG_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seta_en,
    input  logic [REG_W-1:0] seta_idx,
    input  logic [CNT_W-1:0] seta_cnt,
    input  logic             setb_en,
    input  logic [REG_W-1:0] setb_idx,
    input  logic [CNT_W-1:0] setb_cnt,
    output logic [N-1:0]     busy
);
    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [CNT_W-1:0] cnt_d, cnt_q;
        logic hit_a, hit_b;

        always_comb begin
            hit_a = seta_en && (seta_idx == REG_W'(i));
            hit_b = setb_en && (setb_idx == REG_W'(i));
            cnt_d = cnt_q;
            if (hit_a)             cnt_d = seta_cnt;
            else if (hit_b)        cnt_d = setb_cnt;
            else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign busy[i] = (cnt_q != '0);

        // R7: an entry not reloaded counts down by exactly one
        a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q != '0 && !hit_a && !hit_b) |=> (cnt_q == $past(cnt_q) - 1'b1));
    end
endmodule

// File: rtl/dd_pair_check.sv
module dd_pair_check
    import dispatch_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic [ADDR_W-1:0] a0,
    input  logic [ADDR_W-1:0] a1,
    input  logic [CLS_W-1:0]  c0,
    input  logic [CLS_W-1:0]  c1,
    input  logic [REG_N-1:0]  busy,
    output logic              rdy0,
    output logic              rdy1,
    output logic              pairable
);
    logic raw, waw, place_ok;

    always_comb begin
        rdy0 = 1'b1;
        rdy1 = 1'b1;
        raw  = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (f_use(w0, i) && busy[f_src(w0, i)]) rdy0 = 1'b0;
            if (f_use(w1, i) && busy[f_src(w1, i)]) rdy1 = 1'b0;
            if (f_use(w1, i) && f_src(w1, i) == f_dst(w0)) raw = 1'b1;
        end
        waw      = (f_dst(w0) == f_dst(w1));
        place_ok = !a0[0] && (a1 == a0 + 1'b1) && !c0[CLS_W-1] && c1[CLS_W-1];
        pairable = place_ok && !raw && !waw;
    end
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
    import dispatch_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_valid,
    input  logic [31:0]       ins0_word,
    input  logic [ADDR_W-1:0] ins0_addr,
    input  logic [2:0]        ins0_cls,
    input  logic [31:0]       ins1_word,
    input  logic [ADDR_W-1:0] ins1_addr,
    input  logic [2:0]        ins1_cls,
    output logic              fetch_stall,
    output logic              even_valid,
    output logic [31:0]       even_word,
    output logic [2:0]        even_cls,
    output logic              odd_valid,
    output logic [31:0]       odd_word,
    output logic [2:0]        odd_cls
);
    typedef struct packed {
        logic  second;  // first word already issued, second pending
        slot_t ev;
        slot_t od;
    } st_t;

    st_t st_d, st_q;
    logic [REG_N-1:0] busy;
    logic rdy0, rdy1, pairable;
    logic go0, go1, take;

    dd_pair_check #(.ADDR_W(ADDR_W)) u_pair (
        .w0(ins0_word), .w1(ins1_word), .a0(ins0_addr), .a1(ins1_addr),
        .c0(ins0_cls), .c1(ins1_cls), .busy(busy),
        .rdy0(rdy0), .rdy1(rdy1), .pairable(pairable)
    );

    dd_scoreboard #(.N(REG_N)) u_sb (
        .clk(clk), .rst_n(rst_n),
        .seta_en(go0), .seta_idx(f_dst(ins0_word)), .seta_cnt(wait_of(ins0_cls)),
        .setb_en(go1), .setb_idx(f_dst(ins1_word)), .setb_cnt(wait_of(ins1_cls)),
        .busy(busy)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ev.v = 1'b0;
        st_d.od.v = 1'b0;
        go0  = 1'b0;
        go1  = 1'b0;
        take = 1'b0;
        if (pair_valid) begin
            if (!st_q.second) begin
                if (rdy0) begin
                    go0 = 1'b1;
                    if (pairable && rdy1) begin
                        go1  = 1'b1;
                        take = 1'b1;
                    end else begin
                        st_d.second = 1'b1;
                    end
                end
            end else if (rdy1) begin
                go1         = 1'b1;
                take        = 1'b1;
                st_d.second = 1'b0;
            end
        end
        if (go0) begin
            if (ins0_cls[CLS_W-1]) st_d.od = '{v: 1'b1, word: ins0_word, cls: ins0_cls};
            else                   st_d.ev = '{v: 1'b1, word: ins0_word, cls: ins0_cls};
        end
        if (go1) begin
            if (ins1_cls[CLS_W-1]) st_d.od = '{v: 1'b1, word: ins1_word, cls: ins1_cls};
            else                   st_d.ev = '{v: 1'b1, word: ins1_word, cls: ins1_cls};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_stall = pair_valid && !take;
    assign even_valid  = st_q.ev.v;
    assign even_word   = st_q.ev.word;
    assign even_cls    = st_q.ev.cls;
    assign odd_valid   = st_q.od.v;
    assign odd_word    = st_q.od.word;
    assign odd_cls     = st_q.od.cls;

    a_r10_even_route: assert property (@(posedge clk) disable iff (!rst_n)
        even_valid |-> !even_cls[CLS_W-1]);
    a_r10_odd_route: assert property (@(posedge clk) disable iff (!rst_n)
        odd_valid |-> odd_cls[CLS_W-1]);
    a_r6_pair_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (even_valid && odd_valid) |-> (f_dst(even_word) != f_dst(odd_word)));
    a_r3_pair_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (even_valid && odd_valid) |-> !$past(ins0_addr[0]));
    a_r7_dst_marked: assert property (@(posedge clk) disable iff (!rst_n)
        even_valid |-> busy[f_dst(even_word)]);
endmodule

// File: tb/dual_issue_dispatch_tb_top.sv
module dual_issue_dispatch_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pair_valid = 1'b0;
    logic [31:0] w0 = '0, w1 = '0;
    logic [29:0] a0 = '0, a1 = '0;
    logic [2:0]  c0 = '0, c1 = '0;
    logic fetch_stall, even_valid, odd_valid;
    logic [31:0] even_word, odd_word;
    logic [2:0]  even_cls, odd_cls;

    int total = 0, bad = 0, cyc = 0, nst = 0;
    int te [128];
    int to [128];
    bit done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_issue_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
        .ins0_word(w0), .ins0_addr(a0), .ins0_cls(c0),
        .ins1_word(w1), .ins1_addr(a1), .ins1_cls(c1),
        .fetch_stall(fetch_stall),
        .even_valid(even_valid), .even_word(even_word), .even_cls(even_cls),
        .odd_valid(odd_valid), .odd_word(odd_word), .odd_cls(odd_cls)
    );

    always @(negedge clk) begin
        if (even_valid) te[even_word[6:0]] = cyc;
        if (odd_valid)  to[odd_word[6:0]]  = cyc;
    end

    function automatic logic [31:0] mk(int d, int a, int b, int c, int m);
        logic [31:0] w = '0;
        w[6:0] = 7'(d); w[13:7] = 7'(a); w[20:14] = 7'(b); w[27:21] = 7'(c);
        w[31:29] = 3'(m);
        return w;
    endfunction

    function automatic int lat(int c);
        int t[8] = '{2, 4, 6, 7, 4, 6, 4, 6};
        return t[c];
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear();
        for (int i = 0; i < 128; i++) begin te[i] = -1; to[i] = -1; end
    endtask

    task automatic send(logic [31:0] x0, int ad0, int k0, logic [31:0] x1, int ad1, int k1);
        @(negedge clk);
        w0 = x0; a0 = 30'(ad0); c0 = 3'(k0);
        w1 = x1; a1 = 30'(ad1); c1 = 3'(k1);
        pair_valid = 1'b1;
        nst = 0;
        forever begin
            #1;
            if (!fetch_stall) break;
            nst++;
            @(negedge clk);
        end
        @(posedge clk);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        pair_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 even_valid", even_valid, 0);
        chk("R1 odd_valid", odd_valid, 0);
        chk("R1 stall", fetch_stall, 0);
    endtask

    task automatic t_dual();
        clear();
        send(mk(10, 0, 0, 0, 0), 8, 0, mk(11, 0, 0, 0, 0), 9, 4);
        idle(10);
        chk("R3 same cycle", to[11] - te[10], 0);
        chk("R10 even taken", te[10] >= 0, 1);
        chk("R8 no stall on dual", nst, 0);
    endtask

    task automatic t_addr_mismatch();
        clear();
        send(mk(12, 0, 0, 0, 0), 9, 0, mk(13, 0, 0, 0, 0), 10, 4);
        idle(10);
        chk("R4 odd address first", to[13] - te[12], 1);
        chk("R8 one stall cycle", nst, 1);
        clear();
        send(mk(16, 0, 0, 0, 0), 8, 0, mk(17, 0, 0, 0, 0), 11, 4);
        idle(10);
        chk("R4 non-consecutive", to[17] - te[16], 1);
    endtask

    task automatic t_class_mismatch();
        clear();
        send(mk(14, 0, 0, 0, 0), 8, 5, mk(15, 0, 0, 0, 0), 9, 0);
        idle(10);
        chk("R10 odd class first", to[14] >= 0, 1);
        chk("R4 class swap order", te[15] - to[14], 1);
    endtask

    task automatic t_waw();
        clear();
        send(mk(22, 0, 0, 0, 0), 8, 0, mk(22, 0, 0, 0, 0), 9, 4);
        idle(10);
        chk("R6 same dst sequential", to[22] - te[22], 1);
    endtask

    task automatic t_raw_table();
        for (int k = 0; k < 8; k++) begin
            int p;
            clear();
            send(mk(40 + k, 0, 0, 0, 0), 16, k, mk(70 + k, 40 + k, 0, 0, 1), 17, 4);
            idle(12);
            p = (k < 4) ? te[40 + k] : to[40 + k];
            chk($sformatf("R5 R7 R2 class %0d distance", k), to[70 + k] - p, lat(k));
        end
    endtask

    task automatic t_unused_src();
        clear();
        send(mk(50, 0, 50, 0, 1), 8, 3, mk(51, 0, 50, 0, 1), 9, 4);
        idle(10);
        chk("R9 unused source pairs", to[51] - te[50], 0);
    endtask

    task automatic t_cross_pair();
        clear();
        send(mk(60, 0, 0, 0, 0), 8, 1, mk(61, 0, 0, 0, 0), 9, 4);
        send(mk(62, 0, 0, 60, 4), 10, 0, mk(63, 0, 0, 0, 0), 11, 4);
        chk("R8 stall cycles", nst, 3);
        idle(10);
        chk("R7 cross-pair wait", te[62] - te[60], 4);
        chk("R3 pair after wait", to[63] - te[62], 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_dual();
        t_addr_mismatch();
        t_class_mismatch();
        t_waw();
        t_raw_table();
        t_unused_src();
        t_cross_pair();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule